// File: doc/BRIEF.md
# Sideband Message Bridge Register Block

This block lets a host send one message at a time onto an internal sideband fabric by writing a handful of 32-bit registers through a configuration-space style port. The port uses byte offsets and per-byte enables. The host fills in the destination address, the upper address word, the write data, the routing fields and the command. It then sets a go bit. The bridge presents the message on a valid/ready request channel and keeps a busy flag up until the message is finished. It then records a 2-bit completion code and, for reads, the returned data.

A non-posted message finishes when the endpoint's completion arrives. A posted message finishes as soon as the request is accepted and always reports success. While a message is in flight the register set is frozen: host writes are dropped, including a second go. The identification dword at offset 0x00 returns all ones when the hide input is high, so that enumeration software sees an absent function.

Top module: `sbmsg_bridge`

## Requirements
- R1: After reset, every register field reads 0, busy (status bit 0) is 0 and `sb_req_valid` is 0.
- R2: Dword 0xD0 is a fully writable 32-bit address register. Its bits 31:24 drive `sb_req_port`. The dword at 0xDC is the upper address word. `sb_req_addr` is {dword 0xDC, bits 15:0 of 0xD0}.
- R3: Dword 0xD8 has two halves. The low half is the status word: opcode in bits 15:8, posted flag in bit 7, completion code in bits 2:1 (read-only) and busy in bit 0. The high half is the routing word: byte enables in bits 31:28, BAR in bits 26:24 and function ID in bits 23:16; bit 27 always reads 0. These fields drive the matching request outputs. Reads of unmapped or unaligned offsets return 0.
- R4: A write to 0xD8 with byte enable 0 set and data bit 0 equal to 1, made while idle, sets busy and raises `sb_req_valid` at the next edge. The request and all its fields then hold steady until `sb_req_ready` is seen.
- R5: For a non-posted message, busy stays 1 after the request is accepted until `sb_cpl_valid`. At that edge busy clears and bits 2:1 take `sb_cpl_status`. A completion that arrives while the bridge is idle or still requesting is ignored.
- R6: For a posted message, busy clears on the edge where the request is accepted, and the completion code becomes 0.
- R7: Dword 0xD4 holds write data. It is replaced by `sb_cpl_data` only when a completion with status 0 ends a message whose opcode is 0, 4 or 6 (the read opcodes). Otherwise it keeps its value.
- R8: While busy, host writes to any register have no effect and a go write does not start a further message.
- R9: Dword 0x00 reads {DEV_ID, VEN_ID}, or 0xFFFFFFFF while `hide_i` is 1.
- R10: All four completion codes (0 success, 1 not supported, 2 powered down, 3 mixed multicast) are captured without change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hide_i | input | 1 | Makes the identification dword read as all ones |
| cfg_wr | input | 1 | Host write strobe |
| cfg_addr | input | 8 | Host byte offset (dword aligned) |
| cfg_wdata | input | 32 | Host write data |
| cfg_be | input | 4 | Host byte enables |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| sb_req_valid | output | 1 | Sideband request valid |
| sb_req_ready | input | 1 | Sideband request accepted |
| sb_req_port | output | 8 | Destination port |
| sb_req_opcode | output | 8 | Message opcode |
| sb_req_posted | output | 1 | Posted message flag |
| sb_req_fbe | output | 4 | First byte enables |
| sb_req_bar | output | 3 | BAR select |
| sb_req_fid | output | 8 | Function ID |
| sb_req_addr | output | 48 | Target address |
| sb_req_data | output | 32 | Write data |
| sb_cpl_valid | input | 1 | Completion valid |
| sb_cpl_status | input | 2 | Completion code |
| sb_cpl_data | input | 32 | Completion read data |

## Verification
The hardest case to reach is a host write that lands inside the busy window: a new address, a full-word write to 0xD8 with go set, or a write to the data register. This is made harder by the request channel holding the message under back-pressure while the endpoint delays its completion. The stimulus holds `sb_req_ready` low for several cycles and then delays the completion. It issues these writes in both the requesting and the waiting phases and reads the registers back before the next message. Read data capture is tested with a write opcode, with a successful read, and with each failing code, so that updates happen only where they should.

// File: rtl/sbmsg_bridge.sv
module sbmsg_bridge #(
  parameter logic [15:0] VEN_ID = 16'h5A5A,
  parameter logic [15:0] DEV_ID = 16'hB51D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hide_i,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic [3:0]  cfg_be,
  output logic [31:0] cfg_rdata,
  output logic        sb_req_valid,
  input  logic        sb_req_ready,
  output logic [7:0]  sb_req_port,
  output logic [7:0]  sb_req_opcode,
  output logic        sb_req_posted,
  output logic [3:0]  sb_req_fbe,
  output logic [2:0]  sb_req_bar,
  output logic [7:0]  sb_req_fid,
  output logic [47:0] sb_req_addr,
  output logic [31:0] sb_req_data,
  input  logic        sb_cpl_valid,
  input  logic [1:0]  sb_cpl_status,
  input  logic [31:0] sb_cpl_data
);
  localparam logic [5:0] DW_ID = 6'h00, DW_ADDR = 6'h34, DW_DATA = 6'h35,
                         DW_CMD = 6'h36, DW_EXT = 6'h37;
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t         st_q;
  logic [31:0] addr_q, ext_q, data_q;
  logic [7:0]  op_q;
  logic        post_q;
  logic [15:0] rt_q;
  logic [1:0]  resp_q;
  logic        busy_q, wr_ok, rd_op;
  logic [5:0]  dw;

  assign dw     = cfg_addr[7:2];
  assign busy_q = (st_q != S_IDLE);
  assign wr_ok  = cfg_wr && !busy_q && (cfg_addr[1:0] == 2'b00);
  assign rd_op  = (op_q == 8'd0) || (op_q == 8'd4) || (op_q == 8'd6);

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    for (int i = 0; i < 4; i++)
      if (be[i]) old[8*i +: 8] = nw[8*i +: 8];
    return old;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      ext_q  <= '0;
      data_q <= '0;
      op_q   <= '0;
      post_q <= 1'b0;
      rt_q   <= '0;
      resp_q <= '0;
    end else begin
      if (wr_ok) begin
        case (dw)
          DW_ADDR: addr_q <= merge(addr_q, cfg_wdata, cfg_be);
          DW_DATA: data_q <= merge(data_q, cfg_wdata, cfg_be);
          DW_EXT:  ext_q  <= merge(ext_q, cfg_wdata, cfg_be);
          DW_CMD: begin
            if (cfg_be[0]) post_q <= cfg_wdata[7];
            if (cfg_be[1]) op_q <= cfg_wdata[15:8];
            if (cfg_be[2]) rt_q[7:0] <= cfg_wdata[23:16];
            if (cfg_be[3]) begin
              rt_q[15:12] <= cfg_wdata[31:28];
              rt_q[10:8]  <= cfg_wdata[26:24];
            end
          end
          default: ;
        endcase
      end
      case (st_q)
        S_IDLE:
          if (wr_ok && dw == DW_CMD && cfg_be[0] && cfg_wdata[0]) st_q <= S_REQ;
        S_REQ:
          if (sb_req_ready) begin
            if (post_q) begin
              st_q   <= S_IDLE;
              resp_q <= 2'd0;
            end else begin
              st_q <= S_WAIT;
            end
          end
        S_WAIT:
          if (sb_cpl_valid) begin
            st_q   <= S_IDLE;
            resp_q <= sb_cpl_status;
            if (sb_cpl_status == 2'd0 && rd_op) data_q <= sb_cpl_data;
          end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr[1:0] == 2'b00) begin
      case (dw)
        DW_ID:   cfg_rdata = hide_i ? 32'hFFFF_FFFF : {DEV_ID, VEN_ID};
        DW_ADDR: cfg_rdata = addr_q;
        DW_DATA: cfg_rdata = data_q;
        DW_CMD:  cfg_rdata = {rt_q, op_q, post_q, 4'b0, resp_q, busy_q};
        DW_EXT:  cfg_rdata = ext_q;
        default: cfg_rdata = '0;
      endcase
    end
  end

  assign sb_req_valid  = (st_q == S_REQ);
  assign sb_req_port   = addr_q[31:24];
  assign sb_req_opcode = op_q;
  assign sb_req_posted = post_q;
  assign sb_req_fbe    = rt_q[15:12];
  assign sb_req_bar    = rt_q[10:8];
  assign sb_req_fid    = rt_q[7:0];
  assign sb_req_addr   = {ext_q, addr_q[15:0]};
  assign sb_req_data   = data_q;
endmodule

// File: rtl/sbmsg_bridge_chk.sv
module sbmsg_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic [31:0] addr_r,
  input logic [1:0]  resp,
  input logic        valid,
  input logic        ready,
  input logic [7:0]  port,
  input logic [7:0]  opcode,
  input logic        posted,
  input logic [3:0]  fbe,
  input logic [2:0]  bar,
  input logic [7:0]  fid,
  input logic [47:0] addr,
  input logic [31:0] data,
  input logic        cpl_valid,
  input logic [1:0]  cpl_status,
  input logic        hide,
  input logic [7:0]  cfg_addr,
  input logic [31:0] cfg_rdata
);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable({port, opcode, posted, fbe, bar, fid, addr, data}));
  assert_valid_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> busy);
  assert_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !valid && !cpl_valid |=> busy);
  assert_cpl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !valid && cpl_valid |=> !busy && resp == $past(cpl_status));
  assert_posted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready && posted |=> !busy && resp == 2'd0);
  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_r));
  assert_hide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hide && cfg_addr == 8'h00 |-> cfg_rdata == 32'hFFFF_FFFF);
endmodule

bind sbmsg_bridge sbmsg_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .addr_r(addr_q), .resp(resp_q),
  .valid(sb_req_valid), .ready(sb_req_ready), .port(sb_req_port),
  .opcode(sb_req_opcode), .posted(sb_req_posted), .fbe(sb_req_fbe),
  .bar(sb_req_bar), .fid(sb_req_fid), .addr(sb_req_addr), .data(sb_req_data),
  .cpl_valid(sb_cpl_valid), .cpl_status(sb_cpl_status), .hide(hide_i),
  .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata)
);

// File: tb/test_sbmsg_bridge.sv
`timescale 1ns/1ps
module test_sbmsg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, hide_i = 1'b0, cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_rdata;
  logic        sb_req_valid, sb_req_ready = 1'b0, sb_req_posted;
  logic [7:0]  sb_req_port, sb_req_opcode, sb_req_fid;
  logic [3:0]  sb_req_fbe;
  logic [2:0]  sb_req_bar;
  logic [47:0] sb_req_addr;
  logic [31:0] sb_req_data;
  logic        sb_cpl_valid = 1'b0;
  logic [1:0]  sb_cpl_status = '0;
  logic [31:0] sb_cpl_data = '0;

  sbmsg_bridge i_sbmsg_bridge (.*);

  always #2 clk = ~clk;

  // stimulus set up by scenarios, applied by cyc()
  logic i_rst = 0, i_hide = 0, i_wr = 0, i_rdy = 0, i_cv = 0;
  logic [7:0] i_a = 0;
  logic [31:0] i_wd = 0, i_cd = 0;
  logic [3:0] i_be = 0;
  logic [1:0] i_cs = 0;

  // behavioural reference state
  int m_st = 0; // 0 idle, 1 requesting, 2 waiting
  logic [31:0] m_addr = 0, m_ext = 0, m_data = 0;
  logic [7:0] m_op = 0;
  logic m_post = 0;
  logic [3:0] m_fbe = 0;
  logic [2:0] m_bar = 0;
  logic [7:0] m_fid = 0;
  logic [1:0] m_resp = 0;

  int nchk = 0, nfail = 0;
  bit done = 0;
  string focus = "R1";

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s [%s] got %h expected %h at %0t", tag, focus, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    if (a[1:0] != 0) return 0;
    case (a)
      8'h00: return i_hide ? 32'hFFFF_FFFF : 32'hB51D_5A5A;
      8'hD0: return m_addr;
      8'hD4: return m_data;
      8'hD8: return {m_fbe, 1'b0, m_bar, m_fid, m_op, m_post, 4'b0, m_resp, m_st != 0};
      8'hDC: return m_ext;
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(logic [7:0] a);
    case (a)
      8'h00: return "R9";
      8'hD0, 8'hDC: return "R2";
      8'hD4: return "R7";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [31:0] bmerge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    for (int k = 0; k < 4; k++) if (be[k]) o[8*k +: 8] = n[8*k +: 8];
    return o;
  endfunction

  task automatic model_step();
    bit wok;
    if (!i_rst) begin
      m_st = 0; m_addr = 0; m_ext = 0; m_data = 0; m_op = 0; m_post = 0;
      m_fbe = 0; m_bar = 0; m_fid = 0; m_resp = 0;
      return;
    end
    wok = i_wr && m_st == 0 && i_a[1:0] == 0;
    if (m_st == 1 && i_rdy) begin
      if (m_post) begin m_st = 0; m_resp = 0; end
      else m_st = 2;
    end else if (m_st == 2 && i_cv) begin
      m_st = 0;
      m_resp = i_cs;
      if (i_cs == 0 && (m_op == 0 || m_op == 4 || m_op == 6)) m_data = i_cd;
    end else if (wok) begin
      case (i_a)
        8'hD0: m_addr = bmerge(m_addr, i_wd, i_be);
        8'hD4: m_data = bmerge(m_data, i_wd, i_be);
        8'hDC: m_ext  = bmerge(m_ext, i_wd, i_be);
        8'hD8: begin
          if (i_be[1]) m_op = i_wd[15:8];
          if (i_be[2]) m_fid = i_wd[23:16];
          if (i_be[3]) begin m_fbe = i_wd[31:28]; m_bar = i_wd[26:24]; end
          if (i_be[0]) begin
            m_post = i_wd[7];
            if (i_wd[0]) m_st = 1;
          end
        end
        default: ;
      endcase
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    rst_n = i_rst; hide_i = i_hide; cfg_wr = i_wr; cfg_addr = i_a; cfg_wdata = i_wd;
    cfg_be = i_be; sb_req_ready = i_rdy; sb_cpl_valid = i_cv; sb_cpl_status = i_cs;
    sb_cpl_data = i_cd;
    #1;
    chk(rd_tag(i_a), cfg_rdata, exp_rd(i_a));
    chk("R4", sb_req_valid, m_st == 1);
    if (m_st == 1) begin
      chk("R3", {sb_req_opcode, sb_req_posted, sb_req_fbe, sb_req_bar, sb_req_fid},
                {m_op, m_post, m_fbe, m_bar, m_fid});
      chk("R2", {sb_req_port, sb_req_addr}, {m_addr[31:24], m_ext, m_addr[15:0]});
      chk("R3", sb_req_data, m_data);
    end
    model_step();
    i_wr = 0; i_cv = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
    i_wr = 1; i_a = a; i_wd = d; i_be = be; cyc();
  endtask
  task automatic rd(logic [7:0] a);
    i_a = a; cyc();
  endtask
  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask
  task automatic cpl(logic [1:0] s, logic [31:0] d);
    i_cv = 1; i_cs = s; i_cd = d; cyc();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog [%s] got timeout expected completion", focus);
    finish_run();
  end

  initial begin
    focus = "R1";
    i_rst = 0; rd(8'hD8); rd(8'hD0); idle(1);
    i_rst = 1; rd(8'hD8); rd(8'hD4);

    focus = "R9";
    i_hide = 1; rd(8'h00); idle(1);
    i_hide = 0; rd(8'h00); rd(8'h02);

    focus = "R2";
    wr(8'hD0, 32'h2A55_1234, 4'hF); rd(8'hD0);
    wr(8'hDC, 32'h0000_0005, 4'hF); rd(8'hDC);
    wr(8'hD0, 32'h0000_9900, 4'b0010); rd(8'hD0);

    focus = "R3";
    wr(8'hD8, 32'hFB7C_0106, 4'b1110); rd(8'hD8);
    wr(8'hD4, 32'hDEAD_BEEF, 4'hF); rd(8'hD4);

    focus = "R4";
    i_rdy = 0; wr(8'hD8, 32'h0000_0001, 4'b0001); rd(8'hD8); idle(3);

    focus = "R8";
    wr(8'hD0, 32'hFFFF_FFFF, 4'hF); rd(8'hD0);
    wr(8'hD8, 32'hFFFF_FFFF, 4'hF); rd(8'hD8);

    focus = "R5";
    cpl(2'd3, 32'h0); rd(8'hD8);
    i_rdy = 1; cyc(); i_rdy = 0; rd(8'hD8); idle(2);
    focus = "R8";
    wr(8'hD4, 32'h0BAD_0BAD, 4'hF); wr(8'hD8, 32'h0000_0601, 4'b0011); rd(8'hD8);
    focus = "R7";
    cpl(2'd0, 32'h1111_1111); rd(8'hD4); rd(8'hD8); cpl(2'd1, 32'h0); rd(8'hD8);

    focus = "R7";
    wr(8'hD8, 32'h0000_0600, 4'b0010);
    wr(8'hD8, 32'h0000_0001, 4'b0001);
    i_rdy = 1; rd(8'hD8); i_rdy = 0; idle(2);
    cpl(2'd0, 32'hCAFE_F00D); rd(8'hD4); rd(8'hD8);

    focus = "R10";
    for (int s = 1; s < 4; s++) begin
      wr(8'hD8, 32'h0000_0000, 4'b0010);
      wr(8'hD8, 32'h0000_0001, 4'b0001);
      i_rdy = 1; rd(8'hD8); i_rdy = 0; idle(1);
      cpl(s[1:0], 32'h1234_5670 + s); rd(8'hD8); rd(8'hD4);
    end
    wr(8'hD8, 32'h0000_0401, 4'b0011);
    i_rdy = 1; rd(8'hD8); i_rdy = 0;
    cpl(2'd0, 32'h4444_0004); rd(8'hD8); rd(8'hD4);

    focus = "R6";
    wr(8'hD8, 32'h0000_0781, 4'b0011); rd(8'hD8); idle(2);
    i_rdy = 1; cyc(); rd(8'hD8);
    wr(8'hD8, 32'h0000_0081, 4'b0001); rd(8'hD8); rd(8'hD8);
    cpl(2'd2, 32'h5555_5555); rd(8'hD8); rd(8'hD4);
    i_rdy = 0; idle(2);

    finish_run();
  end
endmodule